// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small register bank on a plain request port. It sits beside a workstation I/O companion device and holds eight short control registers. Writes to some of them only store a value. Writes to others also raise one-cycle request pulses toward the rest of the system: a floppy terminal count, a power-off request, a whole-system reset request and a CPU halt request.

The block also watches a power-failing input. When the input changes while the power interrupt is enabled, the block latches a power-fail status bit. It drives a level interrupt for as long as that status and the enable are both set. Software clears the status by writing the auxiliary-2 register.

A request is presented for one cycle with `req_valid`. It is decoded by exact address and by access size. Size encoding: 0 = byte, 1 = halfword, 2 = word. Register offsets: configuration 0x00, diagnostic 0x04, modem control 0x08, auxiliary-1 0x0C, auxiliary-2 0x10, idle control 0x14, LED 0x18 (halfword), system control 0x20 (word).

Read data appears on `rsp_rdata` in the cycle after the request and is 0 in any other cycle. Every request pulse and the interrupt come from registers and change on the clock edge that accepts the request. Any unmapped address reads as 0.

Top module: `aux_sysctl`

## Requirements
- R1: `irq_pwr` is high exactly when auxiliary-2 bit 5 (power-fail status) and configuration bit 3 (power interrupt enable) are both set. It follows writes to either register and changes on the power-failing input.
- R2: A change on `pwr_failing` sets auxiliary-2 bit 5 if the input is now high and configuration bit 3 is set. In every other case the change clears bit 5. Bit 5 does not change while the input is steady.
- R3: A byte write to auxiliary-2 keeps only data bits 0 and 1 and preserves the current bit 5. If data bit 1 is set, every bit except bit 0 is cleared, which drops the power-fail status. Bit 1 never reads back as 1.
- R4: A byte write to auxiliary-2 with data bit 0 set gives a one-cycle pulse on `pwr_off_req`.
- R5: A byte write to auxiliary-1 with data bit 1 set gives a pulse on `fdc_tc` that lasts exactly one cycle. The register stores the other seven bits as written and bit 1 as 0.
- R6: A word write to system-control offset 0x20 with bit 0 set loads 0x00000002 and gives a one-cycle `sys_reset_req` pulse. A write there with bit 0 clear changes nothing. Word writes to 0x24, 0x28 and 0x2C are ignored, and reads of them return 0.
- R7: Reset clears configuration, auxiliary-1, auxiliary-2 and modem control. Diagnostic, LED and system control keep their values through reset.
- R8: Any byte write to idle control (0x14) gives a one-cycle `cpu_halt_req` pulse. A byte read of it returns 0.
- R9: Configuration, diagnostic and modem control are 8-bit byte registers that read back what was written. LED is a 16-bit halfword register at 0x18, and a halfword at 0x1A is not mapped.
- R10: An access whose size does not match the register is ignored. It changes no state, raises no pulse and reads as 0.
- R11: `rsp_rdata` carries the read value in the cycle after a read request and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| pwr_failing | input | 1 | Power-failing indication |
| irq_pwr | output | 1 | Power-fail interrupt level |
| fdc_tc | output | 1 | Floppy terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| cpu_halt_req | output | 1 | CPU halt request pulse |

## Verification
The hardest state to reach is a latched power-fail status together with the interrupt enable. Only an edge on `pwr_failing` can set that status, and only while configuration bit 3 is already set. The bench therefore first parks the input low, clears the status, then programs the enable and only then raises the input. It sweeps every combination of enable, input level and the two accepted auxiliary-2 data bits. It also drops the enable while the status stays latched, which shows that the interrupt follows the enable and not the status alone.

// File: rtl/aux_sysctl.sv
module aux_sysctl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  input  logic              pwr_failing,
  output logic              irq_pwr,
  output logic              fdc_tc,
  output logic              pwr_off_req,
  output logic              sys_reset_req,
  output logic              cpu_halt_req
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_DIAG = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_MDM  = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_AUX1 = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_AUX2 = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_IDLE = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(6'h20);
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;
  localparam int PF_BIT = 5, EN_BIT = 3;

  logic [7:0]  cfg_q, aux1_q, aux2_q, mdm_q, diag_q;
  logic [15:0] led_q;
  logic [31:0] sys_q;
  logic        pf_q;

  wire wr  = req_valid && req_write;
  wire rd  = req_valid && !req_write;
  wire szb = req_size == SZ_B;
  wire wr_cfg  = wr && szb && req_addr == A_CFG;
  wire wr_diag = wr && szb && req_addr == A_DIAG;
  wire wr_mdm  = wr && szb && req_addr == A_MDM;
  wire wr_aux1 = wr && szb && req_addr == A_AUX1;
  wire wr_aux2 = wr && szb && req_addr == A_AUX2;
  wire wr_idle = wr && szb && req_addr == A_IDLE;
  wire wr_led  = wr && req_size == SZ_H && req_addr == A_LED;
  wire wr_sys  = wr && req_size == SZ_W && req_addr == A_SYS;
  wire pf_chg  = pwr_failing != pf_q;

  logic [7:0]  cfg_d, aux2_d, aux2_wr;
  logic [31:0] rmux;

  assign cfg_d = wr_cfg ? req_wdata[7:0] : cfg_q;

  always_comb begin
    aux2_wr = {2'b00, aux2_q[PF_BIT], 3'b000, req_wdata[1:0]};
    if (req_wdata[1]) aux2_wr = {7'b0, req_wdata[0]};
    aux2_d = wr_aux2 ? aux2_wr : aux2_q;
    if (pf_chg) aux2_d[PF_BIT] = pwr_failing && cfg_d[EN_BIT];
  end

  always_comb begin
    rmux = '0;
    unique case (req_addr)
      A_CFG:  if (szb) rmux = {24'b0, cfg_q};
      A_DIAG: if (szb) rmux = {24'b0, diag_q};
      A_MDM:  if (szb) rmux = {24'b0, mdm_q};
      A_AUX1: if (szb) rmux = {24'b0, aux1_q};
      A_AUX2: if (szb) rmux = {24'b0, aux2_q};
      A_LED:  if (req_size == SZ_H) rmux = {16'b0, led_q};
      A_SYS:  if (req_size == SZ_W) rmux = sys_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; aux1_q <= '0; aux2_q <= '0; mdm_q <= '0;
      pf_q <= 1'b0; irq_pwr <= 1'b0; rsp_rdata <= '0;
      fdc_tc <= 1'b0; pwr_off_req <= 1'b0;
      sys_reset_req <= 1'b0; cpu_halt_req <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      aux2_q <= aux2_d;
      pf_q   <= pwr_failing;
      irq_pwr <= aux2_d[PF_BIT] && cfg_d[EN_BIT];
      if (wr_aux1) aux1_q <= req_wdata[7:0] & 8'hFD;
      if (wr_mdm)  mdm_q  <= req_wdata[7:0];
      rsp_rdata     <= rd ? rmux : '0;
      fdc_tc        <= wr_aux1 && req_wdata[1];
      pwr_off_req   <= wr_aux2 && req_wdata[0];
      sys_reset_req <= wr_sys && req_wdata[0];
      cpu_halt_req  <= wr_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_diag) diag_q <= req_wdata[7:0];
    if (wr_led)  led_q  <= req_wdata[15:0];
    if (wr_sys && req_wdata[0]) sys_q <= 32'h2;
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pwr == (aux2_q[PF_BIT] && cfg_q[EN_BIT])); // R1
  AST_PF_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux2_q[PF_BIT]) |-> $past(pf_chg && pwr_failing)); // R2
  AST_AUX2_NO_B1: assert property (@(posedge clk) disable iff (!rst_n)
    !aux2_q[1]); // R3
  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> $past(wr_aux2 && req_wdata[0])); // R4
  AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_tc |-> $past(req_valid && req_write && req_addr == A_AUX1 && req_size == SZ_B && req_wdata[1])); // R5
  AST_SYS_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> sys_q == 32'h2); // R6
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt_req |-> $past(req_valid && req_write && req_addr == A_IDLE)); // R8
  AST_SIZE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_CFG && req_size != SZ_B && !pf_chg) |=> $stable(cfg_q)); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rsp_rdata == 32'h0); // R11
endmodule

// File: tb/aux_sysctl_bench.sv
`timescale 1ns/1ps
module aux_sysctl_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, pwr_failing = 0;
  logic [5:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic irq_pwr, fdc_tc, pwr_off_req, sys_reset_req, cpu_halt_req;
  int total = 0, bad = 0;
  logic p_tc, p_off, p_rst, p_halt, q_tc, q_off, q_rst, q_halt;
  logic [31:0] rv;

  always #10 clk = ~clk;

  aux_sysctl u_aux_sysctl (.clk, .rst_n, .req_valid, .req_write, .req_addr,
    .req_size, .req_wdata, .rsp_rdata, .pwr_failing, .irq_pwr, .fdc_tc,
    .pwr_off_req, .sys_reset_req, .cpu_halt_req);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    p_tc = fdc_tc; p_off = pwr_off_req; p_rst = sys_reset_req; p_halt = cpu_halt_req;
    req_valid = 0; req_write = 0;
    @(negedge clk);
    q_tc = fdc_tc; q_off = pwr_off_req; q_rst = sys_reset_req; q_halt = cpu_halt_req;
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] s);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = s;
    @(negedge clk);
    rv = rsp_rdata;
    req_valid = 0;
    @(negedge clk);
    chk(rsp_rdata == 0, "R11 idle rdata", rsp_rdata, 0);
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk); pwr_failing = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk(irq_pwr == 0 && fdc_tc == 0 && pwr_off_req == 0 && sys_reset_req == 0 && cpu_halt_req == 0,
        "R7 outputs after reset", {irq_pwr, fdc_tc, pwr_off_req, sys_reset_req, cpu_halt_req}, 0);
    rd(6'h00, 0); chk(rv == 0, "R7 cfg reset", rv, 0);
    rd(6'h0C, 0); chk(rv == 0, "R7 aux1 reset", rv, 0);
    rd(6'h10, 0); chk(rv == 0, "R7 aux2 reset", rv, 0);

    for (int v = 0; v < 256; v++) begin
      wr(6'h04, 0, v); rd(6'h04, 0); chk(rv == v, "R9 diag readback", rv, v);
      wr(6'h08, 0, v); rd(6'h08, 0); chk(rv == v, "R9 modem readback", rv, v);
      wr(6'h00, 0, v & 8'hF7); rd(6'h00, 0); chk(rv == (v & 8'hF7), "R9 cfg readback", rv, v & 8'hF7);
      chk(irq_pwr == 0, "R1 no irq without status", irq_pwr, 0);
      wr(6'h0C, 0, v);
      chk(p_tc == v[1], "R5 tc pulse", p_tc, v[1]);
      chk(q_tc == 0, "R5 tc one cycle", q_tc, 0);
      rd(6'h0C, 0); chk(rv == (v & 8'hFD), "R5 aux1 bit1 clear", rv, v & 8'hFD);
    end

    for (int en = 0; en < 2; en++)
      for (int pfv = 0; pfv < 2; pfv++)
        for (int w = 0; w < 4; w++) begin
          logic b5, nb5;
          set_pf(0);
          wr(6'h10, 0, 2);
          wr(6'h00, 0, en << 3);
          set_pf(pfv[0]);
          b5 = en[0] & pfv[0];
          rd(6'h10, 0); chk(rv == (b5 << 5), "R2 status latch", rv, b5 << 5);
          chk(irq_pwr == b5, "R1 irq level", irq_pwr, b5);
          wr(6'h10, 0, w);
          chk(p_off == w[0] && q_off == 0, "R4 power-off pulse", p_off, w[0]);
          nb5 = w[1] ? 1'b0 : b5;
          rd(6'h10, 0); chk(rv == ((nb5 << 5) | w[0]), "R3 aux2 write merge", rv, (nb5 << 5) | w[0]);
          chk(irq_pwr == nb5, "R1 irq after aux2 write", irq_pwr, nb5);
          if (nb5) begin
            wr(6'h00, 0, 0);
            chk(irq_pwr == 0, "R1 irq drops with enable", irq_pwr, 0);
            rd(6'h10, 0); chk(rv[5] == 1, "R1 status kept when enable drops", rv, 32'h20);
            wr(6'h00, 0, 8);
            chk(irq_pwr == 1, "R1 irq back with enable", irq_pwr, 1);
            set_pf(0);
            rd(6'h10, 0); chk(rv[5] == 0, "R2 input fall clears", rv[5], 0);
            chk(irq_pwr == 0, "R1 irq after fall", irq_pwr, 0);
          end
        end
    set_pf(0); wr(6'h00, 0, 0); set_pf(1); wr(6'h00, 0, 8);
    rd(6'h10, 0); chk(rv[5] == 0, "R2 late enable no latch", rv[5], 0);
    chk(irq_pwr == 0, "R1 late enable no irq", irq_pwr, 0);
    set_pf(0);

    wr(6'h14, 0, 32'hAB);
    chk(p_halt == 1 && q_halt == 0, "R8 halt pulse", p_halt, 1);
    rd(6'h14, 0); chk(rv == 0, "R8 idle reads 0", rv, 0);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] lv;
      lv = 16'h1 << i ^ 16'hA5C3;
      wr(6'h18, 1, lv); rd(6'h18, 1); chk(rv == lv, "R9 led readback", rv, lv);
    end
    wr(6'h1A, 1, 16'h1234); rd(6'h18, 1); chk(rv[15:0] == (16'h8000 ^ 16'hA5C3), "R9 led other offset ignored", rv, 16'h8000 ^ 16'hA5C3);
    rd(6'h1A, 1); chk(rv == 0, "R9 led other offset reads 0", rv, 0);

    wr(6'h24, 2, 1); chk(p_rst == 0, "R6 other offset no reset", p_rst, 0);
    rd(6'h24, 2); chk(rv == 0, "R6 other offset reads 0", rv, 0);
    wr(6'h20, 0, 1); chk(p_rst == 0, "R10 byte to sys ignored", p_rst, 0);
    wr(6'h20, 2, 32'hFFFF_FFFF);
    chk(p_rst == 1 && q_rst == 0, "R6 reset pulse", p_rst, 1);
    rd(6'h20, 2); chk(rv == 2, "R6 sys status", rv, 2);
    wr(6'h20, 2, 32'h0); chk(p_rst == 0, "R6 bit0 clear no pulse", p_rst, 0);
    rd(6'h20, 2); chk(rv == 2, "R6 bit0 clear no change", rv, 2);

    wr(6'h00, 0, 8'h55);
    wr(6'h00, 2, 8'hAA); rd(6'h00, 0); chk(rv == 8'h55, "R10 word to cfg ignored", rv, 8'h55);
    rd(6'h00, 2); chk(rv == 0, "R10 wrong size read 0", rv, 0);
    wr(6'h0C, 1, 2); chk(p_tc == 0, "R10 halfword aux1 no tc", p_tc, 0);
    wr(6'h14, 2, 1); chk(p_halt == 0, "R10 word idle no halt", p_halt, 0);
    rd(6'h18, 0); chk(rv == 0, "R10 byte led read 0", rv, 0);

    wr(6'h04, 0, 8'h3C); wr(6'h08, 0, 8'h77); wr(6'h0C, 0, 8'hF1); wr(6'h10, 0, 1);
    do_reset();
    rd(6'h00, 0); chk(rv == 0, "R7 cfg cleared", rv, 0);
    rd(6'h08, 0); chk(rv == 0, "R7 modem cleared", rv, 0);
    rd(6'h0C, 0); chk(rv == 0, "R7 aux1 cleared", rv, 0);
    rd(6'h10, 0); chk(rv == 0, "R7 aux2 cleared", rv, 0);
    rd(6'h04, 0); chk(rv == 8'h3C, "R7 diag kept", rv, 8'h3C);
    rd(6'h20, 2); chk(rv == 2, "R7 sys status kept", rv, 2);
    rd(6'h18, 1); chk(rv == (16'h8000 ^ 16'hA5C3), "R7 led kept", rv, 16'h8000 ^ 16'hA5C3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule